// File: doc/BRIEF.md
# ATA Device Status and Interrupt Register

This block is the device-side status logic of a parallel ATA storage target. It keeps the eight-bit status word, answers host reads at the Status and Alternate Status addresses, drives the active-low interrupt line and accepts Command register writes. An accepted write starts an operation in the internal controller. The host reaches it over a simple register bus with an address, a read strobe, a write strobe and write data. The read data is combinational.

The internal controller reports back through event inputs. A completion pulse carries an error flag. Separate pulses report a write fault and a corrected data error. Level inputs give device readiness, seek/sector-found and data-request state. A three-state machine sets the busy bit and the completion handling: ST_READY (idle), ST_BUSY (operation running) and ST_ERR_HOLD (an error completion whose DRDY update waits for a Status read).

The transitions are as follows. CMD_ACCEPT goes from ST_READY or ST_ERR_HOLD to ST_BUSY. DONE_OK goes from ST_BUSY to ST_READY. DONE_ERR goes from ST_BUSY to ST_ERR_HOLD. STATUS_ACK goes from ST_ERR_HOLD to ST_READY on a Status read.

Top module: `ata_status_reg`

## Requirements
- R1: While reset is asserted the status word reads 0x00, irq_n is 1 and cmd_go is 0.
- R2: The status word bit positions are BSY=7, DRDY=6, DWF=5, DSC=4, DRQ=3, CORR=2, IDX=1, ERR=0. IDX is always 0.
- R3: A write to the command address (7) while BSY=0, DRDY=1 and DSC=1 is accepted. In the next cycle cmd_go is 1 for one cycle, cmd_code holds the written byte and BSY is 1. ERR, DWF and CORR are cleared.
- R4: A command write while BSY=1, DRDY=0 or DSC=0 is ignored. cmd_go stays 0, cmd_code and the status word keep their values, and no interrupt is raised.
- R5: An op_done pulse while busy clears BSY and makes the interrupt pending at the same clock edge. irq_n is 0 from the next cycle.
- R6: A host read of the Status address (7) returns the status word and clears the pending interrupt. irq_n is 1 from the next cycle.
- R7: A host read of the Alternate Status address (6) returns the same word as Status and leaves irq_n unchanged.
- R8: An op_done pulse with op_err high sets ERR. DRDY then keeps the value it had at completion, whatever ready_in does, until a Status read. After that read, DRDY follows ready_in again, taking effect one edge after the read's edge.
- R9: A wr_fault pulse while busy sets DWF, and a corr_evt pulse while busy sets CORR. Both hold until the next accepted command.
- R10: DSC and DRQ show dsc_in and drq_in as sampled at the previous clock edge. Outside an error hold, DRDY likewise shows ready_in as sampled at the previous clock edge.
- R11: host_rdata is 0x00 when no read of the Status or Alternate Status address is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | ADDR_W | Host register address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | CMD_W | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| irq_n | output | 1 | Interrupt request, active low |
| cmd_go | output | 1 | One-cycle pulse: command accepted |
| cmd_code | output | CMD_W | Last accepted command code |
| op_done | input | 1 | Controller: operation finished (pulse) |
| op_err | input | 1 | Controller: the finishing operation failed |
| wr_fault | input | 1 | Controller: write fault (pulse) |
| corr_evt | input | 1 | Controller: corrected data error (pulse) |
| ready_in | input | 1 | Controller: device ready level |
| dsc_in | input | 1 | Controller: seek complete / sector found level |
| drq_in | input | 1 | Controller: data request level |

## Verification
The bench drops ready_in while an error completion is held. A design that let DRDY follow at once would show 0x35 instead of 0x75 before the Status read, and a design that never released the hold would keep 0x75 after the read. Alternate Status reads are interleaved with a pending interrupt to catch a design that acknowledges on either address. Command writes are sent while busy, with DRDY low and with DSC low. A design with loose acceptance would pulse cmd_go, overwrite cmd_code or clear the stale ERR, DWF and CORR bits.

// File: rtl/ata_stat_pkg.sv
package ata_stat_pkg;

    typedef enum logic [1:0] {
        ST_READY    = 2'd0,
        ST_BUSY     = 2'd1,
        ST_ERR_HOLD = 2'd2
    } dev_state_e;

    // Field order is the host-visible bit order, MSB first.
    typedef struct packed {
        logic bsy;
        logic drdy;
        logic dwf;
        logic dsc;
        logic drq;
        logic corr;
        logic idx;
        logic err;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

endpackage

// File: rtl/ata_stat_fsm.sv
module ata_stat_fsm
    import ata_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_ok,
    input  logic       op_done,
    input  logic       op_err,
    input  logic       stat_rd,
    output dev_state_e state,
    output logic       busy,
    output logic       err_hold,
    output logic       done_evt
);

    dev_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:    if (cmd_ok) state_d = ST_BUSY;
            ST_BUSY:     if (op_done) state_d = op_err ? ST_ERR_HOLD : ST_READY;
            ST_ERR_HOLD: begin
                if (cmd_ok)       state_d = ST_BUSY;
                else if (stat_rd) state_d = ST_READY;
            end
            default:     state_d = ST_READY;
        endcase
    end

    always_comb begin
        state    = state_q;
        busy     = (state_q == ST_BUSY);
        err_hold = (state_q == ST_ERR_HOLD);
        done_evt = (state_q == ST_BUSY) && op_done;
    end

endmodule

// File: rtl/ata_stat_flags.sv
module ata_stat_flags
    import ata_stat_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  busy,
    input  logic  err_hold,
    input  logic  cmd_ok,
    input  logic  done_evt,
    input  logic  op_err,
    input  logic  wr_fault,
    input  logic  corr_evt,
    input  logic  ready_in,
    input  logic  dsc_in,
    input  logic  drq_in,
    output stat_t stat
);

    logic drdy_q, dwf_q, dsc_q, drq_q, corr_q, err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy_q <= 1'b0;
            dsc_q  <= 1'b0;
            drq_q  <= 1'b0;
        end else begin
            // DRDY is frozen while an error completion awaits acknowledge.
            if (!err_hold) drdy_q <= ready_in;
            dsc_q <= dsc_in;
            drq_q <= drq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            dwf_q  <= 1'b0;
            corr_q <= 1'b0;
        end else if (cmd_ok) begin
            err_q  <= 1'b0;
            dwf_q  <= 1'b0;
            corr_q <= 1'b0;
        end else begin
            if (done_evt && op_err)  err_q  <= 1'b1;
            if (busy && wr_fault)    dwf_q  <= 1'b1;
            if (busy && corr_evt)    corr_q <= 1'b1;
        end
    end

    always_comb begin
        stat      = '0;
        stat.bsy  = busy;
        stat.drdy = drdy_q;
        stat.dwf  = dwf_q;
        stat.dsc  = dsc_q;
        stat.drq  = drq_q;
        stat.corr = corr_q;
        stat.idx  = 1'b0;
        stat.err  = err_q;
    end

endmodule

// File: rtl/ata_stat_irq.sv
module ata_stat_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done_evt,
    input  logic stat_rd,
    output logic irq_n
);

    logic pend_q;

    // A completion in the same cycle as an acknowledge wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (done_evt) pend_q <= 1'b1;
        else if (stat_rd)  pend_q <= 1'b0;
    end

    assign irq_n = ~pend_q;

endmodule

// File: rtl/ata_status_reg.sv
module ata_status_reg
    import ata_stat_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int CMD_W       = 8,
    parameter int ADDR_STATUS = 7,
    parameter int ADDR_ALT    = 6,
    parameter int ADDR_CMD    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [CMD_W-1:0]  host_wdata,
    output logic [STAT_W-1:0] host_rdata,
    output logic              irq_n,
    output logic              cmd_go,
    output logic [CMD_W-1:0]  cmd_code,
    input  logic              op_done,
    input  logic              op_err,
    input  logic              wr_fault,
    input  logic              corr_evt,
    input  logic              ready_in,
    input  logic              dsc_in,
    input  logic              drq_in
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_ALT  = ADDR_W'(ADDR_ALT);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(ADDR_CMD);

    dev_state_e state_w;
    stat_t      stat_w;
    logic       busy_w, err_hold_w, done_w;
    logic       stat_rd, alt_rd, cmd_wr, cmd_ok;

    assign stat_rd = host_rd && (host_addr == A_STAT);
    assign alt_rd  = host_rd && (host_addr == A_ALT);
    assign cmd_wr  = host_wr && (host_addr == A_CMD);
    assign cmd_ok  = cmd_wr && !stat_w.bsy && stat_w.drdy && stat_w.dsc;

    ata_stat_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_ok   (cmd_ok),
        .op_done  (op_done),
        .op_err   (op_err),
        .stat_rd  (stat_rd),
        .state    (state_w),
        .busy     (busy_w),
        .err_hold (err_hold_w),
        .done_evt (done_w)
    );

    ata_stat_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy_w),
        .err_hold (err_hold_w),
        .cmd_ok   (cmd_ok),
        .done_evt (done_w),
        .op_err   (op_err),
        .wr_fault (wr_fault),
        .corr_evt (corr_evt),
        .ready_in (ready_in),
        .dsc_in   (dsc_in),
        .drq_in   (drq_in),
        .stat     (stat_w)
    );

    ata_stat_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_evt (done_w),
        .stat_rd  (stat_rd),
        .irq_n    (irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_go   <= 1'b0;
            cmd_code <= '0;
        end else begin
            cmd_go <= cmd_ok;
            if (cmd_ok) cmd_code <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (stat_rd || alt_rd) host_rdata = stat_w;
    end

    logic unused_state;
    assign unused_state = ^state_w;

endmodule

// File: rtl/ata_stat_chk.sv
module ata_stat_chk #(
    parameter int ADDR_W      = 3,
    parameter int ADDR_STATUS = 7,
    parameter int ADDR_ALT    = 6,
    parameter int ADDR_CMD    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic              host_wr,
    input logic              irq_n,
    input logic              cmd_go,
    input logic              op_done,
    input logic              drq_in,
    input logic [7:0]        stat,
    input logic              err_hold
);

    p_busy_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> stat[7]);

    p_cmd_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_W'(ADDR_CMD) && (stat[7] || !stat[6] || !stat[4]))
        |=> !cmd_go);

    p_irq_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[7]) |-> !irq_n);

    p_status_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_W'(ADDR_STATUS) && !(stat[7] && op_done)) |=> irq_n);

    p_alt_keeps_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_W'(ADDR_ALT) && !irq_n && !host_wr) |=> !irq_n);

    p_err_drdy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_hold && $past(err_hold)) |-> $stable(stat[6]));

    p_drq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stat[3] == $past(drq_in)));

endmodule

bind ata_status_reg ata_stat_chk #(
    .ADDR_W      (ADDR_W),
    .ADDR_STATUS (ADDR_STATUS),
    .ADDR_ALT    (ADDR_ALT),
    .ADDR_CMD    (ADDR_CMD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .irq_n     (irq_n),
    .cmd_go    (cmd_go),
    .op_done   (op_done),
    .drq_in    (drq_in),
    .stat      (stat_w),
    .err_hold  (err_hold_w)
);

// File: tb/tb_ata_status_reg.sv
`timescale 1ns/1ps
module tb_ata_status_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_n, cmd_go;
    logic [7:0] cmd_code;
    logic       op_done = 0, op_err = 0, wr_fault = 0, corr_evt = 0;
    logic       ready_in = 0, dsc_in = 0, drq_in = 0;

    int n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    ata_status_reg dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_n(irq_n), .cmd_go(cmd_go), .cmd_code(cmd_code),
        .op_done(op_done), .op_err(op_err), .wr_fault(wr_fault),
        .corr_evt(corr_evt), .ready_in(ready_in), .dsc_in(dsc_in), .drq_in(drq_in)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wr_cmd(input logic [7:0] code);
        host_addr = 3'd7; host_wdata = code; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic finish_op(input logic with_err);
        op_done = 1'b1; op_err = with_err;
        @(negedge clk);
        op_done = 1'b0; op_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        ready_in = 1; dsc_in = 1;
        host_addr = 3'd6; host_rd = 1'b1;
        #1 v = host_rdata;
        host_rd = 1'b0;
        check("R1 status in reset", v, 8'h00);
        check("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
        check("R1 cmd_go in reset", {7'd0, cmd_go}, 8'h00);
        rst_n = 1'b1;
        tick(); tick();
        rd_reg(3'd6, v);
        check("R10 DRDY/DSC follow inputs", v, 8'h50);
    endtask

    task automatic t_ok_cycle();
        logic [7:0] v;
        wr_cmd(8'h20);
        check("R3 cmd_go pulse", {7'd0, cmd_go}, 8'h01);
        check("R3 cmd_code", cmd_code, 8'h20);
        rd_reg(3'd6, v);
        check("R3 BSY set", v & 8'h80, 8'h80);
        check("R3 cmd_go one cycle", {7'd0, cmd_go}, 8'h00);
        wr_cmd(8'h99);
        check("R4 ignored while busy cmd_go", {7'd0, cmd_go}, 8'h00);
        check("R4 ignored while busy cmd_code", cmd_code, 8'h20);
        finish_op(1'b0);
        check("R5 irq_n low after done", {7'd0, irq_n}, 8'h00);
        rd_reg(3'd6, v);
        check("R7 alt status value", v, 8'h50);
        check("R7 alt keeps irq", {7'd0, irq_n}, 8'h00);
        rd_reg(3'd7, v);
        check("R6 status value", v, 8'h50);
        check("R6 irq released", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_error_hold();
        logic [7:0] v;
        wr_cmd(8'h30);
        wr_fault = 1; tick(); wr_fault = 0;
        corr_evt = 1; tick(); corr_evt = 0;
        finish_op(1'b1);
        check("R5 irq_n low after error done", {7'd0, irq_n}, 8'h00);
        rd_reg(3'd6, v);
        check("R8 R9 R2 error status word", v, 8'h75);
        ready_in = 0;
        tick(); tick();
        rd_reg(3'd6, v);
        check("R8 DRDY held before status read", v, 8'h75);
        rd_reg(3'd7, v);
        check("R8 status read value", v, 8'h75);
        check("R6 irq released after error", {7'd0, irq_n}, 8'h01);
        tick();
        rd_reg(3'd6, v);
        check("R8 DRDY follows after read", v, 8'h35);
    endtask

    task automatic t_refused();
        logic [7:0] v;
        wr_cmd(8'h40);
        check("R4 ignored with DRDY=0", {7'd0, cmd_go}, 8'h00);
        rd_reg(3'd6, v);
        check("R4 flags untouched DRDY=0", v, 8'h35);
        check("R4 no irq DRDY=0", {7'd0, irq_n}, 8'h01);
        ready_in = 1; dsc_in = 0;
        tick(); tick();
        wr_cmd(8'h41);
        check("R4 ignored with DSC=0", {7'd0, cmd_go}, 8'h00);
        check("R4 cmd_code kept", cmd_code, 8'h30);
        rd_reg(3'd6, v);
        check("R4 flags untouched DSC=0", v, 8'h65);
    endtask

    task automatic t_clear_and_drq();
        logic [7:0] v;
        dsc_in = 1; tick();
        wr_cmd(8'hC8);
        check("R3 accepted after refusals", {7'd0, cmd_go}, 8'h01);
        check("R3 new cmd_code", cmd_code, 8'hC8);
        rd_reg(3'd6, v);
        check("R3 ERR/DWF/CORR cleared", v, 8'hD0);
        finish_op(1'b0);
        rd_reg(3'd7, v);
        check("R6 status after clean op", v, 8'h50);
        drq_in = 1; tick();
        rd_reg(3'd6, v);
        check("R10 DRQ follows input", v, 8'h58);
        host_addr = 3'd7; #1;
        check("R11 rdata idle", host_rdata, 8'h00);
        check("R2 IDX zero", v & 8'h02, 8'h00);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        #2;
        t_reset();
        t_ok_cycle();
        t_error_hold();
        t_refused();
        t_clear_and_drq();
        report();
    end

endmodule